// File: doc/BRIEF.md
# Access Fault Classifier and Error Status Capture

This block sits beside the address path of a processor and a DMA engine. It judges every access presented to it. An access is either allowed or it falls into one of three fault kinds: the page is not present, a user-mode access touched the privileged I/O space, or a user-mode access reached kernel space or wrote to a write-protected page. The classification is combinational and appears in the same cycle as the access.

When a fault occurs, the block latches three 16-bit status words at the next clock edge. The general status word encodes the fault kind, the direction, the bus master and the parity-interrupt enable. The first bus status word encodes the master, the access width, the byte lane and the upper address byte. The second bus status word holds the low address half. When the error-enable control is set, the same edge also raises a one-cycle pulse. This is a bus-error pulse for a processor fault and a level-7 interrupt pulse for a DMA fault. A clear-status strobe sets all three words back to all ones.

The access interface is a plain strobe with no back-pressure. Every access presented with `acc_valid_i` high is judged in that cycle, and the block never stalls the requester.

Top module: `access_fault_capture`

## Requirements
- R1: An access with address below 0x400000 and page state 0 is a page fault, whatever the supervisor bit says.
- R2: A supervisor access that is not a page fault is allowed (`acc_ok_o` high in the same cycle).
- R3: A user access at or above 0x400000 is a privileged-space fault.
- R4: A user access below 0x400000 whose address bits 22:19 are all zero is a kernel-space fault.
- R5: A user write to a page whose write-enable bit is 0 is reported with the kernel-space code.
- R6: A processor fault loads the general status word with 0x8BFF for a page fault, 0x9AFF for a privileged fault and 0x9BFF for a kernel or write-protect fault when writing. A processor read adds 0x4000 to each, giving 0xCBFF, 0xDAFF and 0xDBFF.
- R7: A DMA fault uses 0xABFF, 0xBAFF and 0xBBFF, plus 0x4000 when the DMA is reading. Any fault adds 0x0400 when `pie_i` is 1.
- R8: Bus status word 0 is 0x7C00 for a processor word or long access (`acc_size_i` 1 or 2). It is 0x7D00 for a processor byte access at an even address and 0x7E00 for one at an odd address. It is 0x3C00 for any DMA fault. In every case address bits 23:16 are ORed into bits 7:0.
- R9: Bus status word 1 holds address bits 15:0 of the faulting access.
- R10: The status words update one edge after a fault, regardless of `err_en_i`. In that same cycle, and only if `err_en_i` was 1, `cpu_berr_o` (processor fault) or `dma_nmi_o` (DMA fault) is high for exactly one cycle.
- R11: Reset and the clear strobe set all three status words to 0xFFFF. A fault in the same cycle as the clear strobe takes precedence.
- R12: A later fault overwrites the captured status. Allowed accesses and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_dma_i | input | 1 | 1 = DMA master, 0 = processor |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_super_i | input | 1 | Supervisor mode of the access |
| acc_size_i | input | 2 | 0 byte, 1 word, 2 long |
| acc_addr_i | input | 24 | Byte address |
| page_state_i | input | 2 | Page state from the map entry; 0 = not present |
| page_we_i | input | 1 | Write-enable bit from the map entry |
| err_en_i | input | 1 | Error enable for the pulse outputs |
| pie_i | input | 1 | Parity-interrupt enable, reflected in the status word |
| clr_stat_i | input | 1 | Clear-status strobe |
| acc_ok_o | output | 1 | Current access is valid and allowed |
| cpu_berr_o | output | 1 | One-cycle processor bus-error pulse |
| dma_nmi_o | output | 1 | One-cycle level-7 interrupt pulse for DMA |
| gstat_o | output | 16 | General status word |
| bstat0_o | output | 16 | Bus status word 0 |
| bstat1_o | output | 16 | Bus status word 1 |

## Verification
Two functions can meet in one cycle: a fault capture and a clear-status strobe. A further collision is a fault following directly on another fault. The bench raises `clr_stat_i` in the same cycle as a faulting DMA access and then expects the fault's encoded words, not 0xFFFF. It also issues two faulting accesses on consecutive cycles and expects the second access's words together with a pulse in each of the two following cycles.

// File: rtl/afc_pkg.sv
`timescale 1ns/1ps
package afc_pkg;
  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_PAGE = 2'd1,
    FK_PRIV = 2'd2,
    FK_KERN = 2'd3
  } fault_kind_t;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_t;
endpackage

// File: rtl/afc_classify.sv
`timescale 1ns/1ps
module afc_classify
  import afc_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int IO_BASE = 24'h400000,
  parameter int KSEL_HI = 22,
  parameter int KSEL_LO = 19
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic              super_i,
  input  logic [1:0]        page_state_i,
  input  logic              page_we_i,
  output fault_kind_t       kind_o
);
  logic below_io;

  always_comb begin
    below_io = (addr_i < ADDR_W'(IO_BASE));
    kind_o   = FK_NONE;
    if (below_io && (page_state_i == 2'd0)) begin
      kind_o = FK_PAGE;
    end else if (!super_i) begin
      if (!below_io)                              kind_o = FK_PRIV;
      else if (addr_i[KSEL_HI:KSEL_LO] == '0)     kind_o = FK_KERN;
      else if (write_i && !page_we_i)             kind_o = FK_KERN;
    end
  end
endmodule

// File: rtl/afc_encode.sv
`timescale 1ns/1ps
module afc_encode
  import afc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int STAT_W = 16
) (
  input  fault_kind_t        kind_i,
  input  logic               dma_i,
  input  logic               write_i,
  input  logic               pie_i,
  input  acc_size_t          size_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [STAT_W-1:0]  gstat_o,
  output logic [STAT_W-1:0]  bstat0_o,
  output logic [STAT_W-1:0]  bstat1_o
);
  localparam int HI_W = ADDR_W - STAT_W;

  logic [STAT_W-1:0] kind_base;
  logic [STAT_W-1:0] lane_base;

  always_comb begin
    unique case (kind_i)
      FK_PAGE: kind_base = 16'h8BFF;
      FK_PRIV: kind_base = 16'h9AFF;
      FK_KERN: kind_base = 16'h9BFF;
      default: kind_base = 16'hFFFF;
    endcase
    gstat_o = kind_base
            | (write_i ? 16'h0000 : 16'h4000)
            | (dma_i   ? 16'h2000 : 16'h0000)
            | (pie_i   ? 16'h0400 : 16'h0000);

    if (dma_i)                  lane_base = 16'h3C00;
    else if (size_i != SZ_BYTE) lane_base = 16'h7C00;
    else if (addr_i[0])         lane_base = 16'h7E00;
    else                        lane_base = 16'h7D00;
    bstat0_o = lane_base | STAT_W'(addr_i[ADDR_W-1:STAT_W]);
    bstat1_o = addr_i[STAT_W-1:0];
  end

  if (HI_W > 8) begin : g_wide_hi
    initial $display("afc_encode: upper address field wider than status byte");
  end
endmodule

// File: rtl/afc_capture.sv
`timescale 1ns/1ps
module afc_capture #(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic              clr_i,
  input  logic              dma_i,
  input  logic              err_en_i,
  input  logic [STAT_W-1:0] gstat_d,
  input  logic [STAT_W-1:0] bstat0_d,
  input  logic [STAT_W-1:0] bstat1_d,
  output logic              cpu_berr_o,
  output logic              dma_nmi_o,
  output logic [STAT_W-1:0] gstat_o,
  output logic [STAT_W-1:0] bstat0_o,
  output logic [STAT_W-1:0] bstat1_o
);
  localparam logic [STAT_W-1:0] ALL_ONES = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gstat_o    <= ALL_ONES;
      bstat0_o   <= ALL_ONES;
      bstat1_o   <= ALL_ONES;
      cpu_berr_o <= 1'b0;
      dma_nmi_o  <= 1'b0;
    end else begin
      cpu_berr_o <= cap_i && err_en_i && !dma_i;
      dma_nmi_o  <= cap_i && err_en_i &&  dma_i;
      if (cap_i) begin
        gstat_o  <= gstat_d;
        bstat0_o <= bstat0_d;
        bstat1_o <= bstat1_d;
      end else if (clr_i) begin
        gstat_o  <= ALL_ONES;
        bstat0_o <= ALL_ONES;
        bstat1_o <= ALL_ONES;
      end
    end
  end

  // R10
  berr_needs_ee_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_berr_o || dma_nmi_o) |-> $past(err_en_i && cap_i));

  // R10
  one_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_berr_o && dma_nmi_o));

  // R11
  clear_sets_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_i && !cap_i) |-> (gstat_o == ALL_ONES && bstat0_o == ALL_ONES && bstat1_o == ALL_ONES));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cap_i && !clr_i) |-> ($stable(gstat_o) && $stable(bstat0_o) && $stable(bstat1_o)));
endmodule

// File: rtl/access_fault_capture.sv
`timescale 1ns/1ps
module access_fault_capture
  import afc_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int STAT_W  = 16,
  parameter int IO_BASE = 24'h400000,
  parameter int KSEL_HI = 22,
  parameter int KSEL_LO = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid_i,
  input  logic              acc_dma_i,
  input  logic              acc_write_i,
  input  logic              acc_super_i,
  input  logic [1:0]        acc_size_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [1:0]        page_state_i,
  input  logic              page_we_i,
  input  logic              err_en_i,
  input  logic              pie_i,
  input  logic              clr_stat_i,
  output logic              acc_ok_o,
  output logic              cpu_berr_o,
  output logic              dma_nmi_o,
  output logic [STAT_W-1:0] gstat_o,
  output logic [STAT_W-1:0] bstat0_o,
  output logic [STAT_W-1:0] bstat1_o
);
  fault_kind_t       kind;
  logic              cap;
  logic [STAT_W-1:0] gstat_d, bstat0_d, bstat1_d;

  afc_classify #(
    .ADDR_W(ADDR_W), .IO_BASE(IO_BASE), .KSEL_HI(KSEL_HI), .KSEL_LO(KSEL_LO)
  ) u_classify (
    .addr_i(acc_addr_i), .write_i(acc_write_i), .super_i(acc_super_i),
    .page_state_i(page_state_i), .page_we_i(page_we_i), .kind_o(kind)
  );

  afc_encode #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_encode (
    .kind_i(kind), .dma_i(acc_dma_i), .write_i(acc_write_i), .pie_i(pie_i),
    .size_i(acc_size_t'(acc_size_i)), .addr_i(acc_addr_i),
    .gstat_o(gstat_d), .bstat0_o(bstat0_d), .bstat1_o(bstat1_d)
  );

  assign cap      = acc_valid_i && (kind != FK_NONE);
  assign acc_ok_o = acc_valid_i && (kind == FK_NONE);

  afc_capture #(.STAT_W(STAT_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .cap_i(cap), .clr_i(clr_stat_i),
    .dma_i(acc_dma_i), .err_en_i(err_en_i),
    .gstat_d(gstat_d), .bstat0_d(bstat0_d), .bstat1_d(bstat1_d),
    .cpu_berr_o(cpu_berr_o), .dma_nmi_o(dma_nmi_o),
    .gstat_o(gstat_o), .bstat0_o(bstat0_o), .bstat1_o(bstat1_o)
  );

  // R2
  super_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && acc_super_i && (acc_addr_i >= ADDR_W'(IO_BASE) || page_state_i != 2'd0)) |-> acc_ok_o);

  // R1
  page_fault_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && acc_addr_i < ADDR_W'(IO_BASE) && page_state_i == 2'd0) |-> !acc_ok_o);

  // R9
  low_addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid_i && !acc_ok_o) |-> (bstat1_o == $past(acc_addr_i[STAT_W-1:0])));
endmodule

// File: tb/tb_access_fault_capture.sv
`timescale 1ns/1ps
module tb_access_fault_capture;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid_i = 0, acc_dma_i = 0, acc_write_i = 0, acc_super_i = 0;
  logic [1:0] acc_size_i = 0;
  logic [23:0] acc_addr_i = 0;
  logic [1:0] page_state_i = 0;
  logic page_we_i = 0, err_en_i = 0, pie_i = 0, clr_stat_i = 0;
  logic acc_ok_o, cpu_berr_o, dma_nmi_o;
  logic [15:0] gstat_o, bstat0_o, bstat1_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  access_fault_capture dut (
    .clk(clk), .rst_n(rst_n), .acc_valid_i(acc_valid_i), .acc_dma_i(acc_dma_i),
    .acc_write_i(acc_write_i), .acc_super_i(acc_super_i), .acc_size_i(acc_size_i),
    .acc_addr_i(acc_addr_i), .page_state_i(page_state_i), .page_we_i(page_we_i),
    .err_en_i(err_en_i), .pie_i(pie_i), .clr_stat_i(clr_stat_i),
    .acc_ok_o(acc_ok_o), .cpu_berr_o(cpu_berr_o), .dma_nmi_o(dma_nmi_o),
    .gstat_o(gstat_o), .bstat0_o(bstat0_o), .bstat1_o(bstat1_o)
  );

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=20000 cycles", cycles);
      finish_up();
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // present one access for one cycle; on return we are at the negedge after the capture edge
  task automatic access(input logic dma, input logic wr, input logic sup, input logic [23:0] a,
                        input logic [1:0] sz, input logic [1:0] ps, input logic we,
                        input logic exp_ok);
    @(negedge clk);
    acc_valid_i = 1; acc_dma_i = dma; acc_write_i = wr; acc_super_i = sup;
    acc_addr_i = a; acc_size_i = sz; page_state_i = ps; page_we_i = we;
    #1 chk("R1/R2 acc_ok", {15'd0, acc_ok_o}, {15'd0, exp_ok});
    @(negedge clk);
    acc_valid_i = 0;
  endtask

  task automatic expect_status(input string req, input logic [15:0] g, input logic [15:0] b0,
                               input logic [15:0] b1);
    chk({req, " gstat"}, gstat_o, g);
    chk({req, " bstat0"}, bstat0_o, b0);
    chk({req, " bstat1"}, bstat1_o, b1);
  endtask

  task automatic expect_pulse(input string req, input logic berr, input logic nmi);
    chk({req, " cpu_berr"}, {15'd0, cpu_berr_o}, {15'd0, berr});
    chk({req, " dma_nmi"}, {15'd0, dma_nmi_o}, {15'd0, nmi});
  endtask

  task automatic t_reset();
    expect_status("R11 reset", 16'hFFFF, 16'hFFFF, 16'hFFFF);
    expect_pulse("R10 reset", 0, 0);
  endtask

  task automatic t_cpu_write_page_odd();
    err_en_i = 1; pie_i = 0;
    access(0, 1, 0, 24'h123457, 2'd0, 2'd0, 1, 0);
    expect_status("R1 R6 R8 R9 cpu wr page odd byte", 16'h8BFF, 16'h7E12, 16'h3457);
    expect_pulse("R10 cpu pulse", 1, 0);
    @(negedge clk);
    expect_pulse("R10 single cycle", 0, 0);
  endtask

  task automatic t_super_read_page_pie();
    pie_i = 1;
    access(0, 0, 1, 24'h050000, 2'd1, 2'd0, 1, 0);
    expect_status("R1 R7 super read page pie", 16'hCFFF, 16'h7C05, 16'h0000);
    pie_i = 0;
  endtask

  task automatic t_super_allowed();
    access(0, 1, 1, 24'h400000, 2'd1, 2'd0, 0, 1);
    expect_status("R2 R12 super io allowed", 16'hCFFF, 16'h7C05, 16'h0000);
    expect_pulse("R2 no pulse", 0, 0);
  endtask

  task automatic t_user_priv_no_ee();
    err_en_i = 0;
    access(0, 0, 0, 24'h41ABCD, 2'd2, 2'd1, 1, 0);
    expect_status("R3 R10 user priv ee off", 16'hDAFF, 16'h7C41, 16'hABCD);
    expect_pulse("R10 masked", 0, 0);
    err_en_i = 1;
  endtask

  task automatic t_user_kernel_even();
    access(0, 0, 0, 24'h070010, 2'd0, 2'd1, 1, 0);
    expect_status("R4 R8 user kernel even byte", 16'hDBFF, 16'h7D07, 16'h0010);
  endtask

  task automatic t_user_write_protect();
    access(0, 1, 0, 24'h100000, 2'd1, 2'd2, 0, 0);
    expect_status("R5 user write protect", 16'h9BFF, 16'h7C10, 16'h0000);
  endtask

  task automatic t_user_write_ok();
    access(0, 1, 0, 24'h100000, 2'd1, 2'd2, 1, 1);
    expect_status("R12 allowed keeps status", 16'h9BFF, 16'h7C10, 16'h0000);
    expect_pulse("R12 no pulse", 0, 0);
  endtask

  task automatic t_dma_read_page();
    access(1, 0, 0, 24'h2ABCDE, 2'd0, 2'd0, 1, 0);
    expect_status("R7 R8 dma read page", 16'hEBFF, 16'h3C2A, 16'hBCDE);
    expect_pulse("R10 dma pulse", 0, 1);
  endtask

  task automatic t_dma_write_kernel_pie();
    pie_i = 1;
    access(1, 1, 0, 24'h010000, 2'd1, 2'd1, 1, 0);
    expect_status("R7 dma write kernel pie", 16'hBFFF, 16'h3C01, 16'h0000);
    pie_i = 0;
  endtask

  task automatic t_clear();
    @(negedge clk); clr_stat_i = 1;
    @(negedge clk); clr_stat_i = 0;
    expect_status("R11 clear", 16'hFFFF, 16'hFFFF, 16'hFFFF);
  endtask

  task automatic t_clear_vs_fault();
    @(negedge clk);
    clr_stat_i = 1;
    acc_valid_i = 1; acc_dma_i = 1; acc_write_i = 1; acc_super_i = 0;
    acc_addr_i = 24'h450002; acc_size_i = 2'd1; page_state_i = 2'd1; page_we_i = 1;
    @(negedge clk);
    clr_stat_i = 0; acc_valid_i = 0;
    expect_status("R11 fault beats clear", 16'hBAFF, 16'h3C45, 16'h0002);
    expect_pulse("R11 collision pulse", 0, 1);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    acc_valid_i = 1; acc_dma_i = 0; acc_write_i = 0; acc_super_i = 0;
    acc_addr_i = 24'h200001; acc_size_i = 2'd0; page_state_i = 2'd0; page_we_i = 1;
    @(negedge clk);
    expect_pulse("R12 first pulse", 1, 0);
    acc_dma_i = 1; acc_addr_i = 24'h331111;
    @(negedge clk);
    acc_valid_i = 0;
    expect_status("R12 newest wins", 16'hEBFF, 16'h3C33, 16'h1111);
    expect_pulse("R12 second pulse", 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_cpu_write_page_odd();
    t_super_read_page_pie();
    t_super_allowed();
    t_user_priv_no_ee();
    t_user_kernel_even();
    t_user_write_protect();
    t_user_write_ok();
    t_dma_read_page();
    t_dma_write_kernel_pie();
    t_clear();
    t_clear_vs_fault();
    t_back_to_back();
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule